// File: doc/BRIEF.md
# PCI Host Bridge Control Register File

This block is the control and status register bank of a PCI host bridge. A host reaches it through a byte-addressed request port. Each request carries a byte offset, a size code for 1, 2 or 4 bytes, and right-justified data. The bank decodes the offset and checks that the size is legal at that offset. A legal request updates or returns the addressed register, with per-register write masks and read-as-zero bits applied. An illegal request gets an error response, reads back zero and changes nothing.

Besides the general registers, the bank holds three others. The first is a configuration-address register that reads back its raw value and hands a word-aligned copy to the configuration logic. The second is a two-bit fast back-to-back enable. The third is a command-address register that merges the written client-ID bits into a fixed pattern. A 4-byte data window forwards accesses to PCI I/O space. It emits a one-cycle read or write strobe, an address formed from the stored configuration address, and big-endian byte lanes.

A two-state machine sequences every request. In `ST_IDLE` the port is ready. An accepted request takes the `IDLE->RESP` transition and its response is registered. `ST_RESP` presents that response for one cycle and always takes `RESP->IDLE`.

Top module: `brg_ctl_regs`

## Requirements
- R1: After reset the command-address register reads 0xFFFA0030. The configuration-address, fast back-to-back and general registers read 0. `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. The cycle after acceptance has `rsp_valid` high for exactly one cycle, and `req_ready` is low in that cycle.
- R3: The I/O data window spans offsets 0x004 to 0x007. Offset 0x004 accepts sizes 1, 2 and 4. Offset 0x006 accepts sizes 1 and 2. Offsets 0x005 and 0x007 accept size 1 only. The size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R4: A rejected request gives `rsp_err`=1 and `rsp_rdata`=0. It changes no register and raises no I/O strobe. The following are rejected: offsets outside the map, ordinary registers at an offset whose low two bits are not 0, and size code 3.
- R5: A write to the command-address register (offset 0x00C) stores 0xFFFA0030 OR (data AND 0x0001E000).
- R6: The fast back-to-back register (offset 0x008) keeps only data bits [1:0] of a write. Its other bits read 0.
- R7: The configuration-address register (offset 0x000) accepts 4-byte requests only. It reads back exactly what was written. `cfg_addr` equals that value with bits [1:0] cleared.
- R8: An accepted window request raises `io_wr` or `io_rd` in its accept cycle. `io_addr` is the stored configuration address with bits [1:0] replaced by the request offset bits [1:0], and `io_size` equals `req_size`. Lanes are big-endian: `io_wdata[31:24]` is the byte at `io_addr`. A value of n bytes occupies the top n bytes. A read returns the top n bytes of `io_rdata`, right-justified.
- R9: Reads of general register 1 (0x014) show bit 0 as 0. Reads of general register 2 (0x018) show bits [2:0] as 0. Reads of general register 3 (0x01C, the feature register) show bits 3, 5, 6, 7, 15 and 24 as 0.
- R10: General register 2 stores only data bits [7:0] of a write. General registers 0, 1 and 3 store all 32 bits.
- R11: Ordinary registers accept any legal size at their aligned offset. Write data is zero-extended from the request size, and read data is truncated to the request size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Right-justified read data, 0 on writes and errors |
| cfg_addr | output | 32 | Word-aligned configuration address |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_addr | output | 32 | I/O byte address |
| io_size | output | 2 | I/O size code |
| io_wdata | output | 32 | Big-endian I/O write lanes |
| io_rdata | input | 32 | Big-endian I/O read lanes, sampled in the strobe cycle |

## Verification
The assertions assume that a requester waits for `req_ready` before presenting a new request. They also assume that `req_valid` does not stay high into the response cycle as a second request. The bench drives one request at a time from the falling edge and drops `req_valid` on the falling edge after acceptance. It holds `io_rdata` at a fixed pattern, so that lane selection on reads has a known expected value.

// File: rtl/brg_ctl_pkg.sv
package brg_ctl_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_X = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        K_CFG,
        K_IO,
        K_FBB,
        K_CMD,
        K_GEN,
        K_BAD
    } reg_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    // word indices (byte offset / 4)
    localparam int W_CFG  = 0;
    localparam int W_IO   = 1;
    localparam int W_FBB  = 2;
    localparam int W_CMD  = 3;
    localparam int W_GEN0 = 4;

    localparam logic [31:0] CMD_BASE = 32'hFFFA_0030;
    localparam logic [31:0] CMD_KEEP = 32'h0001_E000;

    function automatic logic [31:0] size_mask(input logic [1:0] s);
        case (s)
            SZ_B:    return 32'h0000_00FF;
            SZ_H:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] gen_keep(input int i);
        case (i)
            2:       return 32'h0000_00FF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] gen_rdmask(input int i);
        case (i)
            1:       return ~32'h0000_0001;
            2:       return ~32'h0000_0007;
            3:       return ~32'h0100_80E8;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/brg_ctl_decode.sv
module brg_ctl_decode
    import brg_ctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_GEN = 4,
    localparam int GIW    = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_kind_e         kind,
    output logic [GIW-1:0]    gen_idx
);
    localparam int WW = ADDR_W - 2;

    logic [WW-1:0] word;
    logic [WW-1:0] gen_off;
    logic [1:0]    sub;
    logic          size_ok;

    assign word    = addr[ADDR_W-1:2];
    assign sub     = addr[1:0];
    assign gen_off = word - WW'(W_GEN0);
    assign gen_idx = gen_off[GIW-1:0];
    assign size_ok = (size != SZ_X);

    always_comb begin
        kind = K_BAD;
        if (size_ok) begin
            if (word == WW'(W_IO)) begin
                unique case (sub)
                    2'd0:    kind = K_IO;
                    2'd2:    kind = (size != SZ_W) ? K_IO : K_BAD;
                    default: kind = (size == SZ_B) ? K_IO : K_BAD;
                endcase
            end else if (sub == 2'd0) begin
                if (word == WW'(W_CFG))
                    kind = (size == SZ_W) ? K_CFG : K_BAD;
                else if (word == WW'(W_FBB))
                    kind = K_FBB;
                else if (word == WW'(W_CMD))
                    kind = K_CMD;
                else if (word >= WW'(W_GEN0) && word < WW'(W_GEN0 + NUM_GEN))
                    kind = K_GEN;
            end
        end
    end
endmodule

// File: rtl/brg_ctl_lane.sv
module brg_ctl_lane
    import brg_ctl_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [31:0] wval,
    input  logic [31:0] lane_in,
    output logic [31:0] lane_out,
    output logic [31:0] rval
);
    logic [4:0] sh;

    always_comb begin
        case (size)
            SZ_B:    sh = 5'd24;
            SZ_H:    sh = 5'd16;
            default: sh = 5'd0;
        endcase
    end

    assign lane_out = wval << sh;
    assign rval     = lane_in >> sh;
endmodule

// File: rtl/brg_ctl_regs.sv
module brg_ctl_regs
    import brg_ctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_GEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [31:0]       cfg_addr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [31:0]       io_addr,
    output logic [1:0]        io_size,
    output logic [31:0]       io_wdata,
    input  logic [31:0]       io_rdata
);
    localparam int GIW = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;

    bus_state_e     state_q, state_d;
    reg_kind_e      kind;
    logic [GIW-1:0] gen_idx;
    logic           accept;
    logic [31:0]    smask, wval, io_rval, rd_val;

    logic [31:0]    cfg_raw_q;
    logic [1:0]     fbb_q;
    logic [31:0]    cmd_q;
    logic [31:0]    gen_q [NUM_GEN];
    logic           err_q;
    logic [31:0]    rdata_q;

    brg_ctl_decode #(.ADDR_W(ADDR_W), .NUM_GEN(NUM_GEN)) u_dec (
        .addr    (req_addr),
        .size    (req_size),
        .kind    (kind),
        .gen_idx (gen_idx)
    );

    brg_ctl_lane u_lane (
        .size     (req_size),
        .wval     (wval),
        .lane_in  (io_rdata),
        .lane_out (io_wdata),
        .rval     (io_rval)
    );

    assign smask  = size_mask(req_size);
    assign wval   = req_wdata & smask;
    assign accept = req_valid && req_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_RESP;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
        endcase
    end

    assign io_wr    = accept && (kind == K_IO) && req_write;
    assign io_rd    = accept && (kind == K_IO) && !req_write;
    assign io_addr  = {cfg_raw_q[31:2], req_addr[1:0]};
    assign io_size  = req_size;
    assign cfg_addr = {cfg_raw_q[31:2], 2'b00};

    always_comb begin
        unique case (kind)
            K_CFG:   rd_val = cfg_raw_q;
            K_IO:    rd_val = io_rval;
            K_FBB:   rd_val = {30'd0, fbb_q};
            K_CMD:   rd_val = cmd_q;
            K_GEN:   rd_val = gen_q[gen_idx] & gen_rdmask(int'(gen_idx));
            default: rd_val = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_raw_q <= 32'd0;
            fbb_q     <= 2'd0;
            cmd_q     <= CMD_BASE;
            err_q     <= 1'b0;
            rdata_q   <= 32'd0;
        end else if (accept) begin
            err_q   <= (kind == K_BAD);
            rdata_q <= (req_write || kind == K_BAD) ? 32'd0 : (rd_val & smask);
            if (req_write) begin
                if (kind == K_CFG) cfg_raw_q <= wval;
                if (kind == K_FBB) fbb_q     <= wval[1:0];
                if (kind == K_CMD) cmd_q     <= CMD_BASE | (wval & CMD_KEEP);
            end
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gen_q[g] <= 32'd0;
            else if (accept && req_write && kind == K_GEN && gen_idx == GIW'(g))
                gen_q[g] <= wval & gen_keep(g);
        end
    end

    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/brg_ctl_regs_chk.sv
module brg_ctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        io_rd,
    input logic        io_wr
);
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r2_busy_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r4_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0));

    a_r4_io_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |=> !rsp_err);

    a_r8_io_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd, io_wr}));

    a_r8_io_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> (req_valid && req_ready));
endmodule

bind brg_ctl_regs brg_ctl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .io_rd     (io_rd),
    .io_wr     (io_wr)
);

// File: tb/brg_ctl_regs_tb.sv
module brg_ctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata, cfg_addr, io_addr, io_wdata;
    logic        io_rd, io_wr;
    logic [1:0]  io_size;
    logic [31:0] io_rdata = 32'h1122_3344;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic        q_err  [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    always #4 clk = ~clk;

    brg_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .cfg_addr(cfg_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            check(req_ready == 1'b0, "R2 ready low in response", {31'd0, req_ready}, 32'd0);
            if (q_err.size() == 0) begin
                check(1'b0, "R2 unexpected response", {31'd0, rsp_valid}, 32'd0);
            end else begin
                logic        e;
                logic [31:0] d;
                string       t;
                e = q_err.pop_front();
                d = q_data.pop_front();
                t = q_tag.pop_front();
                check(rsp_err == e, {t, " err"}, {31'd0, rsp_err}, {31'd0, e});
                check(rsp_rdata == d, {t, " data"}, rsp_rdata, d);
            end
        end
    end

    // driver
    task automatic access(input bit wr, input logic [11:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input bit exp_err, input logic [31:0] exp_rd,
                          input string tag, input bit io_exp = 1'b0,
                          input logic [31:0] io_a = 32'd0, input logic [31:0] io_w = 32'd0);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = sz;
        req_wdata = wd;
        q_err.push_back(exp_err);
        q_data.push_back(exp_rd);
        q_tag.push_back(tag);
        #1;
        if (io_exp) begin
            check(wr ? (io_wr && !io_rd) : (io_rd && !io_wr), {tag, " R8 strobe"},
                  {30'd0, io_rd, io_wr}, wr ? 32'd1 : 32'd2);
            check(io_addr == io_a, {tag, " R8 io_addr"}, io_addr, io_a);
            check(io_size == sz, {tag, " R8 io_size"}, {30'd0, io_size}, {30'd0, sz});
            if (wr) check(io_wdata == io_w, {tag, " R8 io_wdata"}, io_wdata, io_w);
        end else begin
            check(!io_rd && !io_wr, {tag, " no io strobe"}, {30'd0, io_rd, io_wr}, 32'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %08h expected %08h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
        access(0, 12'h00C, 2'd2, 0, 0, 32'hFFFA_0030, "R1 cmd reset");
        access(0, 12'h000, 2'd2, 0, 0, 32'd0, "R1 cfg reset");
        access(0, 12'h008, 2'd2, 0, 0, 32'd0, "R1 fbb reset");
        access(0, 12'h01C, 2'd2, 0, 0, 32'd0, "R1 gen3 reset");

        // R5 command-address merge
        access(1, 12'h00C, 2'd2, 32'hFFFF_FFFF, 0, 0, "R5 cmd write ones");
        access(0, 12'h00C, 2'd2, 0, 0, 32'hFFFB_E030, "R5 cmd read ones");
        access(1, 12'h00C, 2'd2, 32'h1234_5678, 0, 0, "R5 cmd write pattern");
        access(0, 12'h00C, 2'd2, 0, 0, 32'hFFFA_4030, "R5 cmd read pattern");

        // R6 fast back-to-back
        access(1, 12'h008, 2'd2, 32'hFFFF_FFFF, 0, 0, "R6 fbb write");
        access(0, 12'h008, 2'd2, 0, 0, 32'h0000_0003, "R6 fbb read");

        // R7 config address
        access(1, 12'h000, 2'd2, 32'h8000_1237, 0, 0, "R7 cfg write");
        access(0, 12'h000, 2'd2, 0, 0, 32'h8000_1237, "R7 cfg raw read");
        check(cfg_addr == 32'h8000_1234, "R7 cfg_addr aligned", cfg_addr, 32'h8000_1234);
        access(1, 12'h000, 2'd1, 32'h0000_5555, 1, 0, "R7 cfg half write rejected");
        access(0, 12'h000, 2'd0, 0, 1, 0, "R7 cfg byte read rejected");
        access(0, 12'h000, 2'd2, 0, 0, 32'h8000_1237, "R7 cfg unchanged");

        // R8 / R3 I/O window
        access(1, 12'h004, 2'd2, 32'hA1B2_C3D4, 0, 0, "R8 io word write", 1, 32'h8000_1234, 32'hA1B2_C3D4);
        access(1, 12'h006, 2'd1, 32'h0000_BEEF, 0, 0, "R8 io half write", 1, 32'h8000_1236, 32'hBEEF_0000);
        access(1, 12'h007, 2'd0, 32'h0000_005A, 0, 0, "R3 io byte at +3", 1, 32'h8000_1237, 32'h5A00_0000);
        access(0, 12'h004, 2'd2, 0, 0, 32'h1122_3344, "R8 io word read", 1, 32'h8000_1234);
        access(0, 12'h006, 2'd1, 0, 0, 32'h0000_1122, "R8 io half read", 1, 32'h8000_1236);
        access(0, 12'h005, 2'd0, 0, 0, 32'h0000_0011, "R3 io byte at +1", 1, 32'h8000_1235);
        access(1, 12'h006, 2'd2, 32'hFFFF_FFFF, 1, 0, "R3 io word at +2 rejected");
        access(0, 12'h005, 2'd1, 0, 1, 0, "R3 io half at +1 rejected");
        access(0, 12'h007, 2'd2, 0, 1, 0, "R3 io word at +3 rejected");

        // R4 rejections
        access(0, 12'h100, 2'd2, 0, 1, 0, "R4 unmapped offset");
        access(1, 12'h00C, 2'd3, 32'hFFFF_FFFF, 1, 0, "R4 size code 3");
        access(1, 12'h009, 2'd0, 32'h0000_0002, 1, 0, "R4 misaligned fbb");
        access(0, 12'h00C, 2'd2, 0, 0, 32'hFFFA_4030, "R4 cmd unchanged");
        access(0, 12'h008, 2'd2, 0, 0, 32'h0000_0003, "R4 fbb unchanged");

        // R9 / R10 general registers
        access(1, 12'h010, 2'd2, 32'hDEAD_BEEF, 0, 0, "R10 gen0 write");
        access(0, 12'h010, 2'd2, 0, 0, 32'hDEAD_BEEF, "R10 gen0 read");
        access(1, 12'h014, 2'd2, 32'hFFFF_FFFF, 0, 0, "R9 gen1 write");
        access(0, 12'h014, 2'd2, 0, 0, 32'hFFFF_FFFE, "R9 gen1 bit0 zero");
        access(1, 12'h018, 2'd2, 32'hFFFF_FFFF, 0, 0, "R10 gen2 write");
        access(0, 12'h018, 2'd2, 0, 0, 32'h0000_00F8, "R10 gen2 keep and R9 low bits");
        access(1, 12'h01C, 2'd2, 32'hFFFF_FFFF, 0, 0, "R9 feature write");
        access(0, 12'h01C, 2'd2, 0, 0, 32'hFEFF_7F17, "R9 feature reserved zero");

        // R11 narrow access
        access(1, 12'h010, 2'd0, 32'h1234_56AB, 0, 0, "R11 byte write");
        access(0, 12'h010, 2'd2, 0, 0, 32'h0000_00AB, "R11 zero-extended");
        access(1, 12'h010, 2'd2, 32'hCAFE_F00D, 0, 0, "R11 word write");
        access(0, 12'h010, 2'd1, 0, 0, 32'h0000_F00D, "R11 half read truncated");

        repeat (3) @(negedge clk);
        check(q_err.size() == 0, "R2 all responses seen", q_err.size(), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule